// File: doc/BRIEF.md
# Quasi-Bidirectional GPIO Port Controller

This block controls a group of general-purpose pins. Each pin has an output latch bit and a 2-bit mode field. From these, the block derives four digital pad enables: strong pull-up, weak pull-up, very weak pull-up and pull-down. An external pad model uses these enables to drive the pin. Software sets the latch and mode bits through a simple register write port.

Each pin's sampled pad level passes through a glitch filter. The filtered levels are shown on a read port. The filtered level also feeds the quasi-bidirectional drive logic. This lets a pin that is held high only weakly act as an input without changing its mode. When a quasi-bidirectional latch goes from low to high, the block gives the pin a short strong pull-up pulse so that the line rises quickly.

Top module: `qbio_port`

## Requirements
- R1: After reset every pin is in quasi-bidirectional mode with its latch at 1. The read port shows all ones, the weak and very weak pull-ups are on, and the strong pull-up and pull-down are off.
- R2: A write with `wr_sel`=0 loads the latches from `wr_data[NPINS-1:0]`. A write with `wr_sel`=1 loads the modes, with pin i's mode taken from `wr_data[2i+1:2i]`. The encoding is 00 quasi-bidirectional, 01 input-only, 10 push-pull, 11 open-drain. The new value affects the outputs from the first cycle after the write edge.
- R3: In quasi-bidirectional mode, a latch change from 0 to 1 turns on the strong pull-up for exactly two clock cycles, starting in the first cycle after the write edge.
- R4: In quasi-bidirectional mode, a latch of 0 turns the pull-down on and all three pull-ups off.
- R5: In quasi-bidirectional mode, a latch of 1 keeps the very weak pull-up on. The weak pull-up is on only while the filtered input for that pin reads 1.
- R6: In push-pull mode the strong pull-up equals the latch and the pull-down equals the inverted latch. The weak and very weak pull-ups stay off.
- R7: In open-drain mode all pull-ups stay off, even when the latch goes from 0 to 1. The pull-down equals the inverted latch.
- R8: In input-only mode all four enables stay off whatever the latch holds, and the read port still follows the pad.
- R9: A pad level reaches the read port only when it has been sampled at two consecutive clock edges. It appears after the second of those edges. A level present at a single edge is ignored.
- R10: Pull-down and any pull-up are never on together on the same pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 latch register, 1 mode register |
| wr_data | input | 2*NPINS | Write data |
| pad_in | input | NPINS | Sampled pad levels |
| rd_data | output | NPINS | Filtered input levels |
| pu_strong | output | NPINS | Strong pull-up enables |
| pu_weak | output | NPINS | Weak pull-up enables |
| pu_vweak | output | NPINS | Very weak pull-up enables |
| pd_en | output | NPINS | Pull-down enables |

## Verification
The assertions assume that `pad_in` is already synchronous to `clk`. They also assume that a latch register write does not repeat a rising edge faster than the pin can be pulled low, since any 0-to-1 change has to pass through a low latch first. The stimulus changes `pad_in` and the write port only on falling clock edges. It holds each pad level for whole cycles, except in the one deliberate single-cycle glitch. Every rising latch edge is followed by at least three idle cycles before the next write.

// File: rtl/qbio_pkg.sv
package qbio_pkg;

    typedef enum logic [1:0] {
        PM_QUASI     = 2'b00,
        PM_INPUT     = 2'b01,
        PM_PUSHPULL  = 2'b10,
        PM_OPENDRAIN = 2'b11
    } pin_mode_e;

    typedef struct packed {
        logic strong_up;
        logic weak_up;
        logic vweak_up;
        logic pull_dn;
    } pad_drive_t;

    localparam logic SEL_LATCH = 1'b0;
    localparam logic SEL_MODE  = 1'b1;

    // Pad enables for one pin from its mode, latch, filtered level and kick state.
    function automatic pad_drive_t drive_of(pin_mode_e m, logic latch, logic level, logic kick);
        pad_drive_t d;
        d = '0;
        case (m)
            PM_QUASI: begin
                d.strong_up = latch & kick;
                d.weak_up   = latch & level;
                d.vweak_up  = latch;
                d.pull_dn   = ~latch;
            end
            PM_INPUT: d = '0;
            PM_PUSHPULL: begin
                d.strong_up = latch;
                d.pull_dn   = ~latch;
            end
            PM_OPENDRAIN: d.pull_dn = ~latch;
            default: d = '0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/qbio_regs.sv
module qbio_regs
    import qbio_pkg::*;
#(
    parameter int NPINS = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic               wr_sel,
    input  logic [2*NPINS-1:0] wr_data,
    output logic [NPINS-1:0]   latch_q,
    output logic [2*NPINS-1:0] mode_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            latch_q <= '1;
            mode_q  <= {NPINS{PM_QUASI}};
        end else if (wr_en) begin
            if (wr_sel == SEL_LATCH) latch_q <= wr_data[NPINS-1:0];
            else                     mode_q  <= wr_data;
        end
    end

endmodule

// File: rtl/qbio_filter.sv
module qbio_filter (
    input  logic clk,
    input  logic rst,
    input  logic pad_raw,
    output logic level
);

    logic samp_q;

    // A level is accepted when the current sample matches the previous one.
    always_ff @(posedge clk) begin
        if (rst) begin
            samp_q <= 1'b1;
            level  <= 1'b1;
        end else begin
            samp_q <= pad_raw;
            if (pad_raw == samp_q) level <= samp_q;
        end
    end

endmodule

// File: rtl/qbio_drive.sv
module qbio_drive
    import qbio_pkg::*;
#(
    parameter int KICK_CYCLES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] mode,
    input  logic       latch,
    input  logic       level,
    output pad_drive_t drv
);

    localparam int CW = $clog2(KICK_CYCLES + 1);

    pin_mode_e     mode_e;
    logic          prev_q;
    logic [CW-1:0] left_q;
    logic          is_quasi;
    logic          rise;
    logic          kick;

    assign mode_e   = pin_mode_e'(mode);
    assign is_quasi = (mode_e == PM_QUASI);
    assign rise     = is_quasi & latch & ~prev_q;
    assign kick     = rise | (left_q != '0);

    // The cycle of the rise plus KICK_CYCLES-1 counted cycles.
    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b1;
            left_q <= '0;
        end else begin
            prev_q <= latch;
            if (!is_quasi || !latch) left_q <= '0;
            else if (rise)           left_q <= CW'(KICK_CYCLES - 1);
            else if (left_q != '0)   left_q <= left_q - 1'b1;
        end
    end

    assign drv = drive_of(mode_e, latch, level, kick);

endmodule

// File: rtl/qbio_port.sv
module qbio_port
    import qbio_pkg::*;
#(
    parameter int NPINS       = 8,
    parameter int KICK_CYCLES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic               wr_sel,
    input  logic [2*NPINS-1:0] wr_data,
    input  logic [NPINS-1:0]   pad_in,
    output logic [NPINS-1:0]   rd_data,
    output logic [NPINS-1:0]   pu_strong,
    output logic [NPINS-1:0]   pu_weak,
    output logic [NPINS-1:0]   pu_vweak,
    output logic [NPINS-1:0]   pd_en
);

    logic [NPINS-1:0]   latch_q;
    logic [2*NPINS-1:0] mode_q;
    logic [NPINS-1:0]   level;

    qbio_regs #(.NPINS(NPINS)) regs_i (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .latch_q (latch_q),
        .mode_q  (mode_q)
    );

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        pad_drive_t drv;

        qbio_filter filt_i (
            .clk     (clk),
            .rst     (rst),
            .pad_raw (pad_in[i]),
            .level   (level[i])
        );

        qbio_drive #(.KICK_CYCLES(KICK_CYCLES)) drv_i (
            .clk   (clk),
            .rst   (rst),
            .mode  (mode_q[2*i+1:2*i]),
            .latch (latch_q[i]),
            .level (level[i]),
            .drv   (drv)
        );

        assign pu_strong[i] = drv.strong_up;
        assign pu_weak[i]   = drv.weak_up;
        assign pu_vweak[i]  = drv.vweak_up;
        assign pd_en[i]     = drv.pull_dn;
    end

    assign rd_data = level;

endmodule

// File: rtl/qbio_port_chk.sv
module qbio_port_chk
    import qbio_pkg::*;
#(
    parameter int NPINS       = 8,
    parameter int KICK_CYCLES = 2
) (
    input logic               clk,
    input logic               rst,
    input logic [NPINS-1:0]   latch_q,
    input logic [2*NPINS-1:0] mode_q,
    input logic [NPINS-1:0]   pad_in,
    input logic [NPINS-1:0]   rd_data,
    input logic [NPINS-1:0]   pu_strong,
    input logic [NPINS-1:0]   pu_weak,
    input logic [NPINS-1:0]   pu_vweak,
    input logic [NPINS-1:0]   pd_en
);

    localparam int RW = $clog2(KICK_CYCLES + 2) + 1;

    for (genvar i = 0; i < NPINS; i++) begin : g_chk
        logic [1:0]    m;
        logic [RW-1:0] run_q;
        assign m = mode_q[2*i+1:2*i];

        // Length of the current strong pull-up run in quasi mode.
        always_ff @(posedge clk) begin
            if (rst) run_q <= '0;
            else if (m == PM_QUASI && pu_strong[i]) begin
                if (run_q != '1) run_q <= run_q + 1'b1;
            end else run_q <= '0;
        end

        a_r3_kick_bound: assert property (@(posedge clk) disable iff (rst)
            run_q <= RW'(KICK_CYCLES));

        a_r3_kick_start: assert property (@(posedge clk) disable iff (rst)
            ($rose(latch_q[i]) && m == PM_QUASI && $stable(m)) |-> pu_strong[i]);

        a_r10_no_fight: assert property (@(posedge clk) disable iff (rst)
            !(pd_en[i] && (pu_strong[i] || pu_weak[i] || pu_vweak[i])));

        a_r8_input_quiet: assert property (@(posedge clk) disable iff (rst)
            (m == PM_INPUT) |-> !(pd_en[i] || pu_strong[i] || pu_weak[i] || pu_vweak[i]));

        a_r7_od_no_pullup: assert property (@(posedge clk) disable iff (rst)
            (m == PM_OPENDRAIN) |-> !(pu_strong[i] || pu_weak[i] || pu_vweak[i]));

        a_r9_filter_src: assert property (@(posedge clk) disable iff (rst)
            (rd_data[i] != $past(rd_data[i])) |-> (rd_data[i] == $past(pad_in[i])));

        a_r5_weak_needs_high: assert property (@(posedge clk) disable iff (rst)
            pu_weak[i] |-> rd_data[i]);
    end

endmodule

bind qbio_port qbio_port_chk #(.NPINS(NPINS), .KICK_CYCLES(KICK_CYCLES)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .latch_q   (latch_q),
    .mode_q    (mode_q),
    .pad_in    (pad_in),
    .rd_data   (rd_data),
    .pu_strong (pu_strong),
    .pu_weak   (pu_weak),
    .pu_vweak  (pu_vweak),
    .pd_en     (pd_en)
);

// File: tb/qbio_port_tb.sv
`timescale 1ns/1ps
module qbio_port_tb_top;

    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst;
    logic         wr_en;
    logic         wr_sel;
    logic [2*N-1:0] wr_data;
    logic [N-1:0] pad_in;
    logic [N-1:0] rd_data, pu_strong, pu_weak, pu_vweak, pd_en;

    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    qbio_port #(.NPINS(N), .KICK_CYCLES(2)) dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .pad_in(pad_in), .rd_data(rd_data), .pu_strong(pu_strong), .pu_weak(pu_weak),
        .pu_vweak(pu_vweak), .pd_en(pd_en)
    );

    task automatic check(input string req, input string what, input logic [N-1:0] act, input logic [N-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req, input logic [N-1:0] s, input logic [N-1:0] w,
                             input logic [N-1:0] v, input logic [N-1:0] d);
        check(req, "strong", pu_strong, s);
        check(req, "weak",   pu_weak,   w);
        check(req, "vweak",  pu_vweak,  v);
        check(req, "pulldn", pd_en,     d);
    endtask

    // Drives a one-cycle write; returns at the negedge after the write edge.
    task automatic write_reg(input logic sel, input logic [2*N-1:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic t_reset;
        check("R1", "rd_data", rd_data, 4'b1111);
        check_all("R1", 4'b0000, 4'b1111, 4'b1111, 4'b0000);
    endtask

    task automatic t_quasi_low;
        write_reg(1'b0, 8'h0A);                 // R2 latch write
        check_all("R4", 4'b0000, 4'b1010, 4'b1010, 4'b0101);
        idle(3);
        check_all("R4", 4'b0000, 4'b1010, 4'b1010, 4'b0101);
    endtask

    task automatic t_kick;
        write_reg(1'b0, 8'h0F);
        check_all("R3", 4'b0101, 4'b1111, 4'b1111, 4'b0000);
        @(negedge clk);
        check("R3", "strong cycle 2", pu_strong, 4'b0101);
        @(negedge clk);
        check("R3", "strong cycle 3", pu_strong, 4'b0000);
        idle(2);
    endtask

    task automatic t_weak_follows;
        @(negedge clk); pad_in = 4'b0011;
        @(negedge clk);
        check("R9", "rd after one edge", rd_data, 4'b1111);
        @(negedge clk);
        check("R9", "rd after two edges", rd_data, 4'b0011);
        check_all("R5", 4'b0000, 4'b0011, 4'b1111, 4'b0000);
        pad_in = 4'b1111;
        idle(3);
        check("R5", "weak restored", pu_weak, 4'b1111);
    endtask

    task automatic t_glitch;
        @(negedge clk); pad_in = 4'b1110;
        @(negedge clk); pad_in = 4'b1111;
        for (int k = 0; k < 3; k++) begin
            check("R9", "glitch rejected", rd_data, 4'b1111);
            check("R9", "weak kept", pu_weak, 4'b1111);
            @(negedge clk);
        end
    endtask

    task automatic t_modes;
        // pin3 open-drain, pin2 push-pull, pin1 input-only, pin0 quasi
        write_reg(1'b1, 8'b11_10_01_00);
        check_all("R2", 4'b0100, 4'b0001, 4'b0001, 4'b0000);
        check("R6", "pp strong", pu_strong & 4'b0100, 4'b0100);
        write_reg(1'b0, 8'h00);
        check_all("R7", 4'b0000, 4'b0000, 4'b0000, 4'b1101);
        check("R8", "input pin quiet", pd_en & 4'b0010, 4'b0000);
        idle(2);
        write_reg(1'b0, 8'h0F);
        check_all("R6", 4'b0101, 4'b0001, 4'b0001, 4'b0000);
        @(negedge clk);
        check("R7", "od no kick", pu_strong, 4'b0101);
        @(negedge clk);
        check("R6", "pp steady", pu_strong, 4'b0100);
        check("R10", "no fight", pd_en & (pu_strong | pu_weak | pu_vweak), 4'b0000);
    endtask

    task automatic t_input_reads;
        @(negedge clk); pad_in = 4'b1101;
        idle(2);
        check("R8", "input pin read", rd_data, 4'b1101);
        check_all("R8", 4'b0100, 4'b0001, 4'b0001, 4'b0000);
        pad_in = 4'b1111;
        idle(3);
        check("R8", "input pin high", rd_data, 4'b1111);
    endtask

    initial begin
        rst = 1'b1; wr_en = 1'b0; wr_sel = 1'b0; wr_data = '0; pad_in = '1;
        idle(3);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_quasi_low();
        t_kick();
        t_weak_follows();
        t_glitch();
        t_modes();
        t_input_reads();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #100000;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule